// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Fast-Interrupt Routing

This block gathers 72 level-sensitive interrupt lines into one normal interrupt request and one fast interrupt request. The lines come in two banks: 64 peripheral lines and 8 local lines. The controller samples every line once per clock. Each line has an enable bit. Software changes the enable bits only through write-one-to-set and write-one-to-clear registers, so two agents can each change their own bits without a read-modify-write race.

The normal request is high whenever any enabled line is active. The fast request follows a single line that software selects with a 7-bit index. That path uses the line's raw level and does not look at the enable mask. A summary register gives a handler most of what it needs in one read. It holds the enabled local lines, one flag for each 32-line peripheral half, and direct copies of a fixed set of eleven peripheral lines.

The register bus is a plain 32-bit port: a byte address, a write strobe, write data and registered read data. A read returns its data on the clock after the address is presented.

Top module: `intc_two_bank`

## Requirements
- R1: After reset, every enable bit, the fast-interrupt enable and the fast-interrupt select are zero, and both interrupt outputs are low.
- R2: Writing to a set-enable word ORs the ones into the enable mask. The words are: peripheral 31:0 at 0x10, peripheral 63:32 at 0x14, and local at 0x18, where only bits 7:0 are used. Reading a set-enable word returns the current mask, with bits 31:8 reading zero for the local word.
- R3: Writing to a clear-enable word clears the enable bits written as one. The words are 0x1C (peripheral 31:0), 0x20 (peripheral 63:32) and 0x24 (local). Reading a clear-enable word returns the bitwise inverse of the mask as a full 32-bit word, so local clear-enable reads bits 31:8 as one.
- R4: 0x04 reads the pending bits for peripheral lines 31:0 and 0x08 reads them for lines 63:32. A pending bit is the sampled level ANDed with its enable.
- R5: irq_o is high exactly when at least one enabled peripheral or local line is active.
- R6: In the summary word at 0x00, bits 7:0 are the local pending bits. Bit 8 is the OR of peripheral pending bits 31:0, and bit 9 is the OR of peripheral pending bits 63:32.
- R7: Summary bits 10 through 20 copy the pending state of these peripheral lines, in this order: 7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62. Summary bits 31:21 read zero.
- R8: A write to 0x0C loads the fast-interrupt select from bits 6:0 and the fast-interrupt enable from bit 7. Written bits 31:8 are ignored. A read of 0x0C returns the enable in bit 7 and the select in bits 6:0, with the other bits zero.
- R9: With fast interrupts enabled, fiq_o follows the raw sampled level of the selected line, whether or not that line is enabled. Select values 0 to 63 pick peripheral lines, and select values 64 to 71 pick local line (select - 64).
- R10: fiq_o is low when the fast-interrupt enable is zero, or when the select is 72 or higher.
- R11: A read from any address other than the ten listed word offsets, including an address that is not word aligned, returns zero. A write to such an address changes no state.
- R12: A change on an input line shows on irq_o and fiq_o after exactly one rising clock edge. A register write affects the outputs right after the edge that accepts it. Read data is valid after the edge that follows the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_lvl_i | input | 64 | Peripheral interrupt levels |
| loc_lvl_i | input | 8 | Local interrupt levels |
| bus_addr_i | input | 9 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets these corner cases:
- The local clear-enable readback, whose upper 24 bits must read one. A design that inverts only the 8 valid bits returns 0x000000xx there.
- A set write whose data has bits above bit 7. A design that keeps those bits would leak them into the local readback.
- Each of the eleven summary mirror positions, one line at a time. A wrong entry in the list, or a shifted base, lights the wrong summary bit.
- The fast path with the selected line disabled, a local select, and an out-of-range select. A design that gates the fast path by the enable mask, or that wraps out-of-range indices, drives fiq_o wrongly.
- Unaligned and unlisted addresses. A loose decoder would corrupt the masks or return stale data there.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // number of peripheral lines copied into the summary word
    localparam int unsigned MIRROR_N = 11;

    // peripheral line copied into summary mirror slot i (order is behaviour)
    function automatic int unsigned mirror_src(input int unsigned i);
        case (i)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            4:       return 19;
            5:       return 53;
            6:       return 54;
            7:       return 55;
            8:       return 56;
            9:       return 57;
            10:      return 62;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/intc_en_word.sv
// One word of enable mask: write-one-to-set or write-one-to-clear update.
module intc_en_word #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] bits_i,
    input  logic         set_i,
    input  logic         clr_i,
    output logic [W-1:0] nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (set_i) begin
            nxt_o = cur_i | bits_i;
        end else if (clr_i) begin
            nxt_o = cur_i & ~bits_i;
        end
    end
endmodule

// File: rtl/intc_summary.sv
// Builds the summary word: local pending, per-half flags, mirrored lines.
module intc_summary
    import intc_pkg::*;
#(
    parameter int unsigned PERIPH_N = 64,
    parameter int unsigned LOCAL_N  = 8,
    parameter int unsigned DATA_W   = 32
) (
    input  logic [PERIPH_N-1:0] per_pend_i,
    input  logic [LOCAL_N-1:0]  loc_pend_i,
    output logic [DATA_W-1:0]   sum_o
);
    localparam int unsigned PER_WORDS = PERIPH_N / DATA_W;
    localparam int unsigned MIR_BASE  = LOCAL_N + PER_WORDS;

    logic [MIRROR_N-1:0] mir;

    for (genvar i = 0; i < MIRROR_N; i++) begin : g_mir
        localparam int unsigned SRC = mirror_src(i);
        if (SRC < PERIPH_N) begin : g_on
            assign mir[i] = per_pend_i[SRC];
        end else begin : g_off
            assign mir[i] = 1'b0;
        end
    end

    always_comb begin
        sum_o = '0;
        sum_o[LOCAL_N-1:0] = loc_pend_i;
        for (int unsigned w = 0; w < PER_WORDS; w++) begin
            sum_o[LOCAL_N + w] = |per_pend_i[w*DATA_W +: DATA_W];
        end
        sum_o[MIR_BASE +: MIRROR_N] = mir;
    end
endmodule

// File: rtl/intc_fiq_route.sv
// Selects one raw line (peripheral then local) for the fast interrupt.
module intc_fiq_route #(
    parameter int unsigned PERIPH_N = 64,
    parameter int unsigned LOCAL_N  = 8,
    parameter int unsigned SEL_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fiq_en_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [PERIPH_N-1:0] per_lvl_i,
    input  logic [LOCAL_N-1:0]  loc_lvl_i,
    output logic                fiq_o
);
    localparam int unsigned SRC_N = PERIPH_N + LOCAL_N;

    logic [SRC_N-1:0] all_lvl;
    logic             hit;

    assign all_lvl = {loc_lvl_i, per_lvl_i};

    always_comb begin
        hit = 1'b0;
        for (int unsigned k = 0; k < SRC_N; k++) begin
            if (32'(sel_i) == k) begin
                hit = all_lvl[k];
            end
        end
    end

    assign fiq_o = fiq_en_i & hit;

    // R10
    fiq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sel_i) >= SRC_N) |-> !fiq_o);
endmodule

// File: rtl/intc_two_bank.sv
module intc_two_bank
    import intc_pkg::*;
#(
    parameter int unsigned PERIPH_N = 64,
    parameter int unsigned LOCAL_N  = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned SEL_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIPH_N-1:0] per_lvl_i,
    input  logic [LOCAL_N-1:0]  loc_lvl_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_we_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);
    localparam int unsigned PER_WORDS = PERIPH_N / DATA_W;
    // word offsets, derived from the bank count
    localparam int unsigned W_SUM     = 0;
    localparam int unsigned W_PEND    = 1;
    localparam int unsigned W_FIQ     = W_PEND + PER_WORDS;
    localparam int unsigned W_SET     = W_FIQ + 1;
    localparam int unsigned W_SET_LOC = W_SET + PER_WORDS;
    localparam int unsigned W_CLR     = W_SET_LOC + 1;
    localparam int unsigned W_CLR_LOC = W_CLR + PER_WORDS;

    typedef struct packed {
        logic [PERIPH_N-1:0] per_lvl;
        logic [LOCAL_N-1:0]  loc_lvl;
        logic [PERIPH_N-1:0] per_en;
        logic [LOCAL_N-1:0]  loc_en;
        logic                fiq_en;
        logic [SEL_W-1:0]    fiq_sel;
        logic [DATA_W-1:0]   rdata;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-3:0]   word;
    logic                aligned;
    logic                known;
    logic                wr_fiq;
    logic [PER_WORDS-1:0] set_hit, clr_hit;
    logic                set_loc, clr_loc;
    logic [DATA_W-1:0]   per_en_nxt [PER_WORDS];
    logic [LOCAL_N-1:0]  loc_en_nxt;
    logic [PERIPH_N-1:0] per_pend;
    logic [LOCAL_N-1:0]  loc_pend;
    logic [DATA_W-1:0]   sum_word;

    assign word    = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign known   = aligned && (32'(word) <= W_CLR_LOC);
    assign wr_fiq  = bus_we_i && aligned && (32'(word) == W_FIQ);
    assign set_loc = bus_we_i && aligned && (32'(word) == W_SET_LOC);
    assign clr_loc = bus_we_i && aligned && (32'(word) == W_CLR_LOC);

    for (genvar w = 0; w < PER_WORDS; w++) begin : g_bank
        assign set_hit[w] = bus_we_i && aligned && (32'(word) == W_SET + w);
        assign clr_hit[w] = bus_we_i && aligned && (32'(word) == W_CLR + w);
        intc_en_word #(.W(DATA_W)) u_en (
            .cur_i  (st_q.per_en[w*DATA_W +: DATA_W]),
            .bits_i (bus_wdata_i),
            .set_i  (set_hit[w]),
            .clr_i  (clr_hit[w]),
            .nxt_o  (per_en_nxt[w])
        );
    end

    intc_en_word #(.W(LOCAL_N)) u_en_loc (
        .cur_i  (st_q.loc_en),
        .bits_i (bus_wdata_i[LOCAL_N-1:0]),
        .set_i  (set_loc),
        .clr_i  (clr_loc),
        .nxt_o  (loc_en_nxt)
    );

    assign per_pend = st_q.per_lvl & st_q.per_en;
    assign loc_pend = st_q.loc_lvl & st_q.loc_en;

    intc_summary #(
        .PERIPH_N (PERIPH_N),
        .LOCAL_N  (LOCAL_N),
        .DATA_W   (DATA_W)
    ) u_sum (
        .per_pend_i (per_pend),
        .loc_pend_i (loc_pend),
        .sum_o      (sum_word)
    );

    intc_fiq_route #(
        .PERIPH_N (PERIPH_N),
        .LOCAL_N  (LOCAL_N),
        .SEL_W    (SEL_W)
    ) u_fiq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fiq_en_i  (st_q.fiq_en),
        .sel_i     (st_q.fiq_sel),
        .per_lvl_i (st_q.per_lvl),
        .loc_lvl_i (st_q.loc_lvl),
        .fiq_o     (fiq_o)
    );

    assign irq_o       = (|per_pend) | (|loc_pend);
    assign bus_rdata_o = st_q.rdata;

    always_comb begin
        st_d         = st_q;
        st_d.per_lvl = per_lvl_i;
        st_d.loc_lvl = loc_lvl_i;
        for (int unsigned w = 0; w < PER_WORDS; w++) begin
            st_d.per_en[w*DATA_W +: DATA_W] = per_en_nxt[w];
        end
        st_d.loc_en = loc_en_nxt;
        if (wr_fiq) begin
            st_d.fiq_sel = bus_wdata_i[SEL_W-1:0];
            st_d.fiq_en  = bus_wdata_i[SEL_W];
        end

        st_d.rdata = '0;
        if (known) begin
            if (32'(word) == W_SUM) begin
                st_d.rdata = sum_word;
            end
            for (int unsigned w = 0; w < PER_WORDS; w++) begin
                if (32'(word) == W_PEND + w) st_d.rdata = per_pend[w*DATA_W +: DATA_W];
                if (32'(word) == W_SET + w)  st_d.rdata = st_q.per_en[w*DATA_W +: DATA_W];
                if (32'(word) == W_CLR + w)  st_d.rdata = ~st_q.per_en[w*DATA_W +: DATA_W];
            end
            if (32'(word) == W_FIQ) begin
                st_d.rdata = DATA_W'({st_q.fiq_en, st_q.fiq_sel});
            end
            if (32'(word) == W_SET_LOC) begin
                st_d.rdata = DATA_W'(st_q.loc_en);
            end
            if (32'(word) == W_CLR_LOC) begin
                st_d.rdata = ~DATA_W'(st_q.loc_en);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit[0] |=> ((st_q.per_en[DATA_W-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R3
    clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit[0] |=> ((st_q.per_en[DATA_W-1:0] & $past(bus_wdata_i)) == '0));

    // R11
    bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && !known) |=> ($stable(st_q.per_en) && $stable(st_q.loc_en)
                                  && $stable(st_q.fiq_en) && $stable(st_q.fiq_sel)));

    // R5
    irq_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|sum_word[LOCAL_N + PER_WORDS - 1:0]));

    // R8
    fiq_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fiq |=> (st_q.fiq_sel == $past(bus_wdata_i[SEL_W-1:0])
                    && st_q.fiq_en == $past(bus_wdata_i[SEL_W])));
endmodule

// File: tb/sim_intc_two_bank.sv
module sim_intc_two_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] plvl = '0;
    logic [7:0]  llvl = '0;
    logic [8:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    intc_two_bank u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .per_lvl_i   (plvl),
        .loc_lvl_i   (llvl),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic lvl(input logic [63:0] p, input logic [7:0] l);
        @(negedge clk);
        plvl = p; llvl = l;
        @(negedge clk);
    endtask

    task automatic clear_all();
        wr(9'h01C, 32'hFFFF_FFFF);
        wr(9'h020, 32'hFFFF_FFFF);
        wr(9'h024, 32'hFFFF_FFFF);
    endtask

    function automatic int unsigned mir(input int unsigned i);
        int unsigned t [11];
        t = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
        return t[i];
    endfunction

    function automatic logic [31:0] model_sum(input logic [63:0] pp, input logic [7:0] lp);
        logic [31:0] s;
        s = {24'b0, lp};
        s[8] = |pp[31:0];
        s[9] = |pp[63:32];
        for (int i = 0; i < 11; i++) s[10 + i] = pp[mir(i)];
        return s;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 fiq after reset", {31'b0, fiq}, 32'h0);
        rd(9'h010, v); chk("R1 enable lo", v, 32'h0);
        rd(9'h014, v); chk("R1 enable hi", v, 32'h0);
        rd(9'h018, v); chk("R1 enable local", v, 32'h0);
        rd(9'h00C, v); chk("R1 fiq control", v, 32'h0);
        rd(9'h024, v); chk("R3 local clear readback at reset", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(9'h010, 32'h0000_00F0);
        wr(9'h010, 32'h0000_000F);
        rd(9'h010, v); chk("R2 set lo accumulates", v, 32'h0000_00FF);
        wr(9'h01C, 32'h0000_0003);
        rd(9'h010, v); chk("R3 clear lo", v, 32'h0000_00FC);
        rd(9'h01C, v); chk("R3 clear lo readback", v, 32'hFFFF_FF03);
        wr(9'h014, 32'h8000_0001);
        rd(9'h014, v); chk("R2 set hi", v, 32'h8000_0001);
        rd(9'h020, v); chk("R3 clear hi readback", v, 32'h7FFF_FFFE);
        wr(9'h018, 32'hFFFF_FF1F);
        rd(9'h018, v); chk("R2 local uses low 8 bits", v, 32'h0000_001F);
        wr(9'h024, 32'h0000_000F);
        rd(9'h018, v); chk("R3 clear local", v, 32'h0000_0010);
        rd(9'h024, v); chk("R3 clear local readback", v, 32'hFFFF_FFEF);
        clear_all();
        rd(9'h010, v); chk("R3 clear all lo", v, 32'h0);
    endtask

    task automatic t_pending();
        logic [63:0] pl [4];
        logic [63:0] pe [4];
        logic [7:0]  ll [4];
        logic [7:0]  le [4];
        logic [31:0] v;
        pl = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_0000_0000_0000,
               64'h0123_4567_89AB_CDEF, 64'h0};
        pe = '{64'h0000_0000_0000_0080, 64'hFFFF_FFFF_0000_0000,
               64'hF0F0_F0F0_0F0F_0F0F, 64'hFFFF_FFFF_FFFF_FFFF};
        ll = '{8'h00, 8'h81, 8'h5A, 8'h00};
        le = '{8'hFF, 8'h01, 8'hF0, 8'hFF};
        for (int k = 0; k < 4; k++) begin
            clear_all();
            wr(9'h010, pe[k][31:0]);
            wr(9'h014, pe[k][63:32]);
            wr(9'h018, {24'b0, le[k]});
            lvl(pl[k], ll[k]);
            rd(9'h004, v); chk("R4 pending lo", v, pl[k][31:0] & pe[k][31:0]);
            rd(9'h008, v); chk("R4 pending hi", v, pl[k][63:32] & pe[k][63:32]);
            rd(9'h000, v); chk("R6 summary", v, model_sum(pl[k] & pe[k], ll[k] & le[k]));
            chk("R5 irq level", {31'b0, irq},
                {31'b0, (|(pl[k] & pe[k])) | (|(ll[k] & le[k]))});
        end
    endtask

    task automatic t_mirror();
        logic [31:0] v;
        logic [31:0] e;
        clear_all();
        wr(9'h010, 32'hFFFF_FFFF);
        wr(9'h014, 32'hFFFF_FFFF);
        for (int i = 0; i < 11; i++) begin
            lvl(64'd1 << mir(i), 8'h00);
            rd(9'h000, v);
            e = (32'd1 << (10 + i)) | ((mir(i) < 32) ? 32'h100 : 32'h200);
            chk("R7 mirror slot", v, e);
        end
        lvl(64'd1 << 8, 8'h00);
        rd(9'h000, v); chk("R7 unlisted line not mirrored", v, 32'h100);
        lvl(64'h0, 8'h00);
    endtask

    task automatic t_irq_timing();
        clear_all();
        wr(9'h018, 32'h0000_0008);
        lvl(64'hFFFF_FFFF_FFFF_FFFF, 8'hF7);
        chk("R5 no enabled line active", {31'b0, irq}, 32'h0);
        @(negedge clk);
        llvl = 8'h08;
        #5;
        chk("R12 irq not yet changed", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R12 irq after one edge", {31'b0, irq}, 32'h1);
        wr(9'h024, 32'h0000_0008);
        chk("R12 irq drops after clear write", {31'b0, irq}, 32'h0);
        lvl(64'h0, 8'h00);
    endtask

    task automatic t_fiq();
        logic [31:0] v;
        clear_all();
        wr(9'h00C, 32'hFFFF_FF85);
        rd(9'h00C, v); chk("R8 fiq control readback", v, 32'h0000_0085);
        lvl(64'h20, 8'h00);
        chk("R9 fiq follows disabled line", {31'b0, fiq}, 32'h1);
        chk("R9 irq stays low", {31'b0, irq}, 32'h0);
        lvl(64'h0, 8'h00);
        chk("R9 fiq follows low level", {31'b0, fiq}, 32'h0);
        wr(9'h00C, 32'h0000_00C3);
        lvl(64'h0, 8'h08);
        chk("R9 fiq local line 3", {31'b0, fiq}, 32'h1);
        lvl(64'hFFFF_FFFF_FFFF_FFFF, 8'hF7);
        chk("R9 fiq local line 3 low", {31'b0, fiq}, 32'h0);
        wr(9'h00C, 32'h0000_00BF);
        lvl(64'h8000_0000_0000_0000, 8'h00);
        chk("R9 fiq peripheral 63", {31'b0, fiq}, 32'h1);
        wr(9'h00C, 32'h0000_00E4);
        lvl(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        chk("R10 select out of range", {31'b0, fiq}, 32'h0);
        wr(9'h00C, 32'h0000_0005);
        chk("R10 fiq disabled", {31'b0, fiq}, 32'h0);
        rd(9'h00C, v); chk("R8 disabled readback", v, 32'h0000_0005);
        wr(9'h00C, 32'h0);
        lvl(64'h0, 8'h00);
    endtask

    task automatic t_badaddr();
        logic [31:0] v;
        clear_all();
        wr(9'h010, 32'h0000_1234);
        wr(9'h028, 32'hFFFF_FFFF);
        wr(9'h011, 32'hFFFF_FFFF);
        wr(9'h01D, 32'hFFFF_FFFF);
        wr(9'h0C0, 32'hFFFF_FFFF);
        rd(9'h010, v); chk("R11 mask unchanged", v, 32'h0000_1234);
        rd(9'h00C, v); chk("R11 fiq control unchanged", v, 32'h0);
        rd(9'h028, v); chk("R11 unlisted read", v, 32'h0);
        rd(9'h011, v); chk("R11 unaligned read", v, 32'h0);
        rd(9'h1FC, v); chk("R11 top read", v, 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        total++;
        $display("FAIL R12 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_pending();
        t_mirror();
        t_irq_timing();
        t_fiq();
        t_badaddr();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule